// File: doc/BRIEF.md
# Clock-Crossing Register Write Bridge

This block lets a bus in the system clock domain update a small bank of control registers that are clocked by a separate, slower watchdog clock. A write is accepted in the system domain and its address and data are latched into a holding register. A single request toggle then crosses into the watchdog domain, where the register is updated. An acknowledge toggle comes back the other way. The bus is never stalled while this happens. Instead, a completion flag in the most significant bit of the control register (address 0) reads 0 while a write is in transit and 1 once it has taken effect. Software polls this flag before it issues another write, or a read that must see the new value.

Reads are combinational from a system-domain mirror of the committed register values, so any number of reads can be issued back to back. A write that arrives while the flag is 0 is discarded. The discard is recorded in a sticky error bit (bit 30 of the control register) that only reset clears.

The write port uses a valid/ready handshake:
- `wr_ready` is low during reset and held high afterwards, so the port never applies back-pressure.
- A transfer happens on any rising `sys_clk` edge where both `wr_valid` and `wr_ready` are high.
- A transfer that happens while the flag is 0 is a discard, not a stall.

A parameter selects a variant for an instance whose registers run on the system clock. In that variant there is no crossing and no flag, and bit 31 reads 0.

Top module: `xdw_bridge`

## Requirements
- R1: After reset the control register (address 0) reads 0x80000000, every other register reads 0, the watchdog-domain outputs are 0, and `wr_ready` is 1.
- R2: A write transfer accepted while the flag is 1 clears bit 31 of the control register, and the cleared flag is visible on the first read after the accepting edge.
- R3: The flag returns to 1 only after the written value has appeared on `wd_regs`. It returns within a bounded number of cycles (two synchronizer stages in each direction).
- R4: A write transfer accepted while the flag is 0 is discarded. No register, mirror or watchdog-domain output changes, and bit 30 of the control register is set and stays 1 until reset.
- R5: Reads are combinational and may be issued on consecutive cycles to any address. While a write is pending, a read of its target returns the previous committed value. After completion it returns the new value.
- R6: The address and data that cross into the watchdog domain are the ones captured at acceptance. Later changes on `wr_data`/`wr_addr` do not alter a pending write.
- R7: Bits 31 and 30 of the control register cannot be written. A write to address 0 stores only bits 29:0, and those bits read back as written.
- R8: With `MODE` set to the system-clock variant, bit 31 always reads 0, a write is visible on the read port and `wd_regs` from the cycle after acceptance, and writes on consecutive cycles are all kept.
- R9: `wd_wr_pulse` is high for exactly one watchdog-clock cycle per committed write, and never for a discarded one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System (bus) clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset, system domain |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write port ready (high whenever out of reset) |
| wr_addr | input | ADDR_W | Register index of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Register index to read |
| rd_data | output | DATA_W | Read data (combinational, control register carries status bits) |
| wd_clk | input | 1 | Watchdog-domain clock |
| wd_rst_n | input | 1 | Asynchronous active-low reset, watchdog domain |
| wd_regs | output | NUM_REGS*DATA_W | Register bank as seen in the watchdog domain, register i at bits i*DATA_W upward |
| wd_wr_pulse | output | 1 | One-cycle strobe in the watchdog domain per committed write |

## Verification
The hardest situation to reach from the ports is a discarded write. It requires a second transfer while the first is still in transit, and a slow watchdog clock is what keeps that window open. The bench issues the second write on the cycle right after the first is accepted. The watchdog clock is set several times slower than the system clock and is not a multiple of it, so the acknowledge cannot have returned by then. After the first write completes, the bench confirms that the second target's register and the pulse count are unchanged and that the sticky bit is set. The bench also changes `wr_data` to a different value while each write is pending, to show that the captured value is the one that crosses.

// File: rtl/xdw_pkg.sv
package xdw_pkg;
  typedef enum logic [0:0] {
    XDW_SYNC  = 1'b0,
    XDW_ASYNC = 1'b1
  } xdw_mode_e;

  localparam int unsigned XDW_CTRL_IDX   = 0;
  localparam int unsigned XDW_DEF_STAGES = 2;
endpackage

// File: rtl/xdw_toggle_sync.sv
module xdw_toggle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], tgl_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign pulse = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/xdw_src_ctl.sv
module xdw_src_ctl #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              req_tgl,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  input  logic              ack_tgl
);
  localparam int unsigned NUM_REGS = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] CTRL_KEEP = {2'b00, {(DATA_W-2){1'b1}}};

  logic              rdy_q;
  logic              done_q;
  logic              err_q;
  logic              ack_pulse;
  logic              accept;
  logic              launch;
  logic [DATA_W-1:0] mirror [NUM_REGS];
  logic [DATA_W-1:0] commit_val;

  xdw_toggle_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .tgl_in (ack_tgl),
    .pulse  (ack_pulse)
  );

  assign wr_ready = rdy_q;
  assign accept   = wr_valid && rdy_q;
  assign launch   = accept && done_q;
  assign commit_val = (cap_addr == ADDR_W'(xdw_pkg::XDW_CTRL_IDX)) ? (cap_data & CTRL_KEEP) : cap_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q    <= 1'b0;
      done_q   <= 1'b1;
      err_q    <= 1'b0;
      req_tgl  <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
      for (int i = 0; i < NUM_REGS; i++) mirror[i] <= '0;
    end else begin
      rdy_q <= 1'b1;
      if (ack_pulse) begin
        done_q           <= 1'b1;
        mirror[cap_addr] <= commit_val;
      end
      if (launch) begin
        cap_addr <= wr_addr;
        cap_data <= wr_data;
        req_tgl  <= ~req_tgl;
        done_q   <= 1'b0;
      end
      if (accept && !done_q) err_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data = mirror[rd_addr];
    if (rd_addr == ADDR_W'(xdw_pkg::XDW_CTRL_IDX)) begin
      rd_data[DATA_W-1] = done_q;
      rd_data[DATA_W-2] = err_q;
    end
  end

  // R2: a launched write clears the completion flag
  p_flag_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !done_q);
  // R6: capture holds while a write is in flight
  p_capture_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |=> ($stable(cap_addr) && $stable(cap_data)));
  // R4: a transfer during flight marks the error
  p_drop_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !done_q) |=> err_q);
  // R4: error bit is sticky
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R3: flag only rises on a returning acknowledge
  p_flag_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && !ack_pulse) |=> !done_q);
endmodule

// File: rtl/xdw_dst_regs.sv
module xdw_dst_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_tgl,
  input  logic [ADDR_W-1:0]                cap_addr,
  input  logic [DATA_W-1:0]                cap_data,
  output logic                             ack_tgl,
  output logic [(1<<ADDR_W)*DATA_W-1:0]    regs_flat,
  output logic                             wr_pulse
);
  localparam int unsigned NUM_REGS = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] CTRL_KEEP = {2'b00, {(DATA_W-2){1'b1}}};

  logic              req_pulse;
  logic [DATA_W-1:0] bank [NUM_REGS];

  xdw_toggle_sync #(.STAGES(STAGES)) u_req_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .tgl_in (req_tgl),
    .pulse  (req_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_tgl  <= 1'b0;
      wr_pulse <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else begin
      wr_pulse <= req_pulse;
      if (req_pulse) begin
        bank[cap_addr] <= (cap_addr == ADDR_W'(xdw_pkg::XDW_CTRL_IDX)) ? (cap_data & CTRL_KEEP) : cap_data;
        ack_tgl        <= ~ack_tgl;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*DATA_W +: DATA_W] = bank[g];
  end

  // R9: commit strobe lasts a single cycle
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
  // R3: acknowledge toggles only together with a commit strobe
  p_ack_with_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_tgl) |-> wr_pulse);
endmodule

// File: rtl/xdw_direct_regs.sv
module xdw_direct_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  output logic [(1<<ADDR_W)*DATA_W-1:0] regs_flat,
  output logic                          wr_pulse
);
  localparam int unsigned NUM_REGS = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] CTRL_KEEP = {2'b00, {(DATA_W-2){1'b1}}};

  logic              rdy_q;
  logic              accept;
  logic [DATA_W-1:0] kept;
  logic [DATA_W-1:0] bank [NUM_REGS];

  assign wr_ready = rdy_q;
  assign accept   = wr_valid && rdy_q;
  assign kept     = (wr_addr == ADDR_W'(xdw_pkg::XDW_CTRL_IDX)) ? (wr_data & CTRL_KEEP) : wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q    <= 1'b0;
      wr_pulse <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else begin
      rdy_q    <= 1'b1;
      wr_pulse <= accept;
      if (accept) bank[wr_addr] <= kept;
    end
  end

  assign rd_data = bank[rd_addr];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*DATA_W +: DATA_W] = bank[g];
  end

  // R8: every accepted write lands on the next edge
  p_direct_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (bank[$past(wr_addr)] == $past(kept)));
endmodule

// File: rtl/xdw_bridge.sv
module xdw_bridge #(
  parameter xdw_pkg::xdw_mode_e MODE   = xdw_pkg::XDW_ASYNC,
  parameter int unsigned        DATA_W = 32,
  parameter int unsigned        ADDR_W = 2,
  parameter int unsigned        STAGES = xdw_pkg::XDW_DEF_STAGES
) (
  input  logic                          sys_clk,
  input  logic                          sys_rst_n,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  input  logic                          wd_clk,
  input  logic                          wd_rst_n,
  output logic [(1<<ADDR_W)*DATA_W-1:0] wd_regs,
  output logic                          wd_wr_pulse
);
  if (MODE == xdw_pkg::XDW_ASYNC) begin : g_async
    logic              req_tgl;
    logic              ack_tgl;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;

    xdw_src_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAGES(STAGES)) u_src (
      .clk      (sys_clk),
      .rst_n    (sys_rst_n),
      .wr_valid (wr_valid),
      .wr_ready (wr_ready),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .req_tgl  (req_tgl),
      .cap_addr (cap_addr),
      .cap_data (cap_data),
      .ack_tgl  (ack_tgl)
    );

    xdw_dst_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAGES(STAGES)) u_dst (
      .clk       (wd_clk),
      .rst_n     (wd_rst_n),
      .req_tgl   (req_tgl),
      .cap_addr  (cap_addr),
      .cap_data  (cap_data),
      .ack_tgl   (ack_tgl),
      .regs_flat (wd_regs),
      .wr_pulse  (wd_wr_pulse)
    );
  end else begin : g_sync
    logic unused_wd_side;
    assign unused_wd_side = ^{wd_clk, wd_rst_n};

    xdw_direct_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_direct (
      .clk       (sys_clk),
      .rst_n     (sys_rst_n),
      .wr_valid  (wr_valid),
      .wr_ready  (wr_ready),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .regs_flat (wd_regs),
      .wr_pulse  (wd_wr_pulse)
    );
  end
endmodule

// File: tb/xdw_bridge_bench.sv
module xdw_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_PERIOD  = 37;

  logic        sys_clk = 0, wd_clk = 0;
  logic        sys_rst_n = 0, wd_rst_n = 0;
  logic        wr_valid = 0, wr_valid_s = 0;
  logic [1:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic        wr_ready, wr_ready_s;
  logic [31:0] rd_data, rd_data_s;
  logic [127:0] wd_regs, wd_regs_s;
  logic        wd_wr_pulse, wd_wr_pulse_s;

  int checks = 0, fails = 0;
  int pulses = 0;
  bit done = 0;
  logic [31:0] exp_reg [4];

  always #(CLK_PERIOD/2) sys_clk = ~sys_clk;
  always #(WD_PERIOD/2)  wd_clk  = ~wd_clk;
  always @(posedge wd_clk) if (wd_wr_pulse) pulses++;

  xdw_bridge u_xdw_bridge (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .wd_clk(wd_clk), .wd_rst_n(wd_rst_n), .wd_regs(wd_regs), .wd_wr_pulse(wd_wr_pulse));

  xdw_bridge #(.MODE(xdw_pkg::XDW_SYNC)) u_xdw_bridge_sys (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wr_valid(wr_valid_s), .wr_ready(wr_ready_s),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_s),
    .wd_clk(sys_clk), .wd_rst_n(sys_rst_n), .wd_regs(wd_regs_s), .wd_wr_pulse(wd_wr_pulse_s));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge sys_clk); rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge sys_clk); wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge sys_clk); wr_valid = 0; wr_addr = ~a; wr_data = 32'h5A5A_0F0F;
  endtask

  task automatic wait_flag(output int n);
    logic [31:0] d;
    n = 0;
    rd_addr = 0; #1; d = rd_data;
    while (!d[31] && n < 200) begin
      @(negedge sys_clk); rd_addr = 0; #1; d = rd_data; n++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      rd(i[1:0], d);
      check("R1 reset read", d, (i == 0) ? 32'h8000_0000 : 32'h0);
    end
    check("R1 wd_regs", (wd_regs == 0) ? 32'd1 : 32'd0, 32'd1);
    check("R1 wr_ready", {31'd0, wr_ready}, 32'd1);
    rd_addr = 0; #1;
    check("R8 sys variant bit31 at reset", rd_data_s, 32'h0);
  endtask

  task automatic t_commit(input logic [1:0] a, input logic [31:0] d);
    logic [31:0] r, kept;
    int n, p0;
    kept = (a == 0) ? (d & 32'h3FFF_FFFF) : d;
    p0 = pulses;
    wr(a, d);
    rd_addr = 0; #1;
    check("R2 flag cleared after accept", {31'd0, rd_data[31]}, 32'd0);
    if (a != 0) begin
      rd_addr = a; #1;
      check("R5 pending read returns old", rd_data, exp_reg[a]);
    end
    wait_flag(n);
    check("R3 flag returns in bound", (n < 200) ? 32'd1 : 32'd0, 32'd1);
    check("R3/R6 wd value on flag rise", wd_regs[a*32 +: 32], kept);
    exp_reg[a] = kept;
    rd(a, r);
    check("R5 readback after commit", (a == 0) ? {2'b00, r[29:0]} : r, kept);
    repeat (12) @(negedge sys_clk);
    check("R9 one strobe per write", pulses - p0, 1);
  endtask

  task automatic t_ctrl_ro;
    logic [31:0] r;
    t_commit(0, 32'hFFFF_FFFF);
    rd(0, r);
    check("R7 ctrl readonly bits", r, 32'hBFFF_FFFF);
    check("R7 wd ctrl stored", wd_regs[31:0], 32'h3FFF_FFFF);
  endtask

  task automatic t_drop;
    logic [31:0] r;
    int n, p0;
    p0 = pulses;
    @(negedge sys_clk); wr_valid = 1; wr_addr = 1; wr_data = 32'h1111_2222;
    @(negedge sys_clk); wr_addr = 2; wr_data = 32'h9999_AAAA;
    @(negedge sys_clk); wr_valid = 0;
    wait_flag(n);
    exp_reg[1] = 32'h1111_2222;
    repeat (12) @(negedge sys_clk);
    check("R4 dropped target wd", wd_regs[64 +: 32], exp_reg[2]);
    rd(2, r);
    check("R4 dropped target mirror", r, exp_reg[2]);
    rd(1, r);
    check("R4 first write kept", r, 32'h1111_2222);
    rd(0, r);
    check("R4 error bit set", {31'd0, r[30]}, 32'd1);
    check("R9 no strobe for dropped", pulses - p0, 1);
  endtask

  task automatic t_sticky;
    logic [31:0] r;
    t_commit(3, 32'h0BAD_F00D);
    rd(0, r);
    check("R4 error sticky", {31'd0, r[30]}, 32'd1);
    check("R7 ctrl after drop", r, 32'hFFFF_FFFF);
  endtask

  task automatic t_reads;
    for (int k = 0; k < 8; k++) begin
      logic [31:0] r;
      rd(k[1:0], r);
      if (k[1:0] != 0) check("R5 back-to-back reads", r, exp_reg[k[1:0]]);
    end
  endtask

  task automatic t_sys_variant;
    @(negedge sys_clk); wr_valid_s = 1; wr_addr = 2; wr_data = 32'hCAFE_0002;
    @(negedge sys_clk); wr_addr = 0; wr_data = 32'hFFFF_0001;
    rd_addr = 2; #1;
    check("R8 sys variant immediate", rd_data_s, 32'hCAFE_0002);
    @(negedge sys_clk); wr_valid_s = 0;
    rd_addr = 0; #1;
    check("R8 sys variant bit31 0", rd_data_s, 32'h3FFF_0001);
    check("R8 sys variant wd side", wd_regs_s[64 +: 32], 32'hCAFE_0002);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) exp_reg[i] = 0;
    repeat (4) @(negedge wd_clk);
    @(negedge sys_clk); sys_rst_n = 1; wd_rst_n = 1;
    repeat (2) @(negedge sys_clk);
    t_reset();
    t_commit(1, 32'hA5A5_1234);
    t_commit(2, 32'h0000_00FF);
    t_ctrl_ro();
    t_reads();
    t_drop();
    t_sticky();
    t_reads();
    t_sys_variant();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule